// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Register Interface

This block is a register-access slave for a host processor on a shared 8-bit address/data bus. A static mode input selects one of two strobe styles. In the first style an address-latch strobe is followed by separate active-low read and write strobes. In the second style an address strobe is followed by an active-high data strobe, and a direction line is high for a read. In both styles the host first places the address on the shared lines and then transfers data on the same lines.

The block samples the host signals on its own clock. It captures the address when the address strobe falls and decodes it against a 256-location space. Nine locations are backed by byte registers. On a write it commits the captured byte when the write ends. On a read it drives the addressed byte through a separate output and an output-enable, and releases the bus at a point that depends on the mode. The registers configure line and framing logic that sits outside this block.

Top module: `hbus_regif`

## Requirements
- R1: After synchronous reset, every implemented register reads 0x00 and `ad_oe` is low.
- R2: The address is taken from `ad_i` when `adr_stb` falls while `cs_n` is low, in either mode. It applies to the following data phase.
- R3: With `bus_mode` = 0, a write commits when `strb_b` (write, active low) rises. The value stored is the one present on `ad_i` while the strobe was still low.
- R4: With `bus_mode` = 0, `ad_oe` is high and `ad_o` carries the addressed byte while `strb_a` (read, active low) is low. `ad_oe` returns low after `strb_a` rises.
- R5: With `bus_mode` = 1, a write commits when `strb_a` (data strobe, active high) falls while `strb_b` (direction) is low. The value stored is the one on `ad_i` while the data strobe was high.
- R6: With `bus_mode` = 1, `ad_oe` is high while `strb_a` is high and `strb_b` is high (read). It returns low after `strb_a` falls, even if `strb_b` stays high.
- R7: While `cs_n` is high, strobes are ignored. No address is latched, no register changes, and `ad_oe` stays low.
- R8: A read of an unimplemented address returns 0x00, and a write to one changes no register.
- R9: The implemented byte registers, all readable and writable, are at 0x15 (test, must hold 0x00 for normal use), 0x1A (common control), 0x2B and 0x2C (receive control), 0x35 and 0x36 (transmit control), and 0x4D, 0x4E and 0x4F (transmit signaling).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the host signals |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 1 | Static strobe style: 0 latch/read/write, 1 strobe/data/direction |
| cs_n | input | 1 | Active-low chip select |
| adr_stb | input | 1 | Address latch enable or address strobe; address is taken on its fall |
| strb_a | input | 1 | Mode 0: read strobe, active low. Mode 1: data strobe, active high |
| strb_b | input | 1 | Mode 0: write strobe, active low. Mode 1: direction, high = read |
| ad_i | input | 8 | Shared bus value as seen by the block |
| ad_o | output | 8 | Read data to be driven onto the shared bus |
| ad_oe | output | 1 | High while the block drives the shared bus |

## Verification
On every cycle the assertions check that the bus is driven only under chip select. They also check that, in each mode, the drive enable follows the read strobe condition of the previous sample, and that reset leaves the bus released. Only the bench scenarios can show that the right byte reaches the right register. This covers address capture on the strobe fall, write data taken from the strobe-active phase, the read-back values, and the absence of any effect from deselected or unmapped accesses.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic {
        MODE_LATCH_RW = 1'b0,
        MODE_STROBE_DIR = 1'b1
    } bus_mode_e;

    localparam int NSLOT = 9;

    localparam logic [7:0] SLOT_ADDR [NSLOT] = '{
        8'h15, 8'h1A, 8'h2B, 8'h2C, 8'h35, 8'h36, 8'h4D, 8'h4E, 8'h4F
    };

    typedef struct packed {
        logic       sel_n;
        logic       astb;
        logic       sa;
        logic       sb;
        logic [7:0] data;
    } bus_smp_t;

    function automatic logic is_mapped(input logic [7:0] a);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (SLOT_ADDR[i] == a) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/hb_strobe_decode.sv
module hb_strobe_decode
    import hbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_mode_e  mode,
    input  logic       cs_n,
    input  logic       adr_stb,
    input  logic       strb_a,
    input  logic       strb_b,
    input  logic [7:0] ad_i,
    output logic       latch_pls,
    output logic       commit_pls,
    output logic       drive_en,
    output logic [7:0] addr_bus,
    output logic [7:0] wdata
);
    bus_smp_t cur, prv, idle;

    always_comb begin
        idle.sel_n = 1'b1;
        idle.astb  = 1'b0;
        idle.sa    = (mode == MODE_LATCH_RW);
        idle.sb    = 1'b1;
        idle.data  = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= idle;
            prv <= idle;
        end else begin
            cur <= '{sel_n: cs_n, astb: adr_stb, sa: strb_a, sb: strb_b, data: ad_i};
            prv <= cur;
        end
    end

    assign latch_pls = !cur.sel_n && prv.astb && !cur.astb;
    assign addr_bus  = cur.data;
    assign wdata     = prv.data;

    always_comb begin
        if (mode == MODE_LATCH_RW) begin
            commit_pls = !cur.sel_n && !prv.sb && cur.sb;
            drive_en   = !cur.sel_n && !cur.sa;
        end else begin
            commit_pls = !cur.sel_n && prv.sa && !cur.sa && !prv.sb;
            drive_en   = !cur.sel_n && cur.sa && cur.sb;
        end
    end
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile
    import hbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] slot_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (wr_en && addr == SLOT_ADDR[g])
                slot_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (addr == SLOT_ADDR[i]) rdata = slot_q[i];
        end
    end
endmodule

// File: rtl/hbus_regif.sv
module hbus_regif
    import hbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_mode,
    input  logic          cs_n,
    input  logic          adr_stb,
    input  logic          strb_a,
    input  logic          strb_b,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe
);
    localparam int AW = 8;

    bus_mode_e       mode;
    logic            latch_pls, commit_pls, drive_en;
    logic [AW-1:0]   addr_bus, addr_q;
    logic [DW-1:0]   wdata, rdata;

    assign mode = bus_mode_e'(bus_mode);

    hb_strobe_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .cs_n       (cs_n),
        .adr_stb    (adr_stb),
        .strb_a     (strb_a),
        .strb_b     (strb_b),
        .ad_i       (ad_i),
        .latch_pls  (latch_pls),
        .commit_pls (commit_pls),
        .drive_en   (drive_en),
        .addr_bus   (addr_bus),
        .wdata      (wdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (latch_pls)
            addr_q <= addr_bus;
    end

    hb_regfile #(.DW(DW)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .wr_en (commit_pls),
        .addr  (addr_q),
        .wdata (wdata),
        .rdata (rdata)
    );

    assign ad_oe = drive_en;
    assign ad_o  = drive_en ? rdata : '0;
endmodule

// File: rtl/hbus_regif_chk.sv
module hbus_regif_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_mode,
    input logic       cs_n,
    input logic       strb_a,
    input logic       strb_b,
    input logic       ad_oe
);
    // R1
    reset_release_chk: assert property (@(posedge clk) $past(rst) |-> !ad_oe);

    // R7
    drive_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> !$past(cs_n));

    // R4
    latch_mode_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_mode && ad_oe) |-> !$past(strb_a));

    // R6
    strobe_mode_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_mode && ad_oe) |-> ($past(strb_a) && $past(strb_b)));

    // R4
    latch_mode_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_mode && $past(strb_a) && !$past(rst)) |-> !ad_oe);
endmodule

bind hbus_regif hbus_regif_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_mode (bus_mode),
    .cs_n     (cs_n),
    .strb_a   (strb_a),
    .strb_b   (strb_b),
    .ad_oe    (ad_oe)
);

// File: tb/hbus_regif_test.sv
module hbus_regif_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_mode = 1'b0;
    logic       cs_n = 1'b1;
    logic       adr_stb = 1'b0;
    logic       strb_a = 1'b1;
    logic       strb_b = 1'b1;
    logic [7:0] ad_i = 8'h00;
    logic [7:0] ad_o;
    logic       ad_oe;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    hbus_regif uut (
        .clk(clk), .rst(rst), .bus_mode(bus_mode), .cs_n(cs_n),
        .adr_stb(adr_stb), .strb_a(strb_a), .strb_b(strb_b),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe)
    );

    task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: on each start of a drive phase, pop the oldest expectation.
    logic oe_d = 1'b0;
    always @(negedge clk) begin
        if (ad_oe && !oe_d) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "unexpected drive", ad_o, 8'h00);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(ad_o === e.val, e.tag, ad_o, e.val);
            end
        end
        oe_d = ad_oe;
    end

    task automatic set_idle();
        adr_stb = 1'b0;
        strb_a  = (bus_mode == 1'b0);
        strb_b  = 1'b1;
    endtask

    task automatic addr_phase(input logic [7:0] a);
        ad_i = a; adr_stb = 1'b1; wait_n(2);
        adr_stb = 1'b0; wait_n(2);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        cs_n = ~sel;
        addr_phase(a);
        ad_i = d;
        if (!bus_mode) begin
            strb_b = 1'b0; wait_n(3); strb_b = 1'b1; wait_n(2);
        end else begin
            strb_b = 1'b0; strb_a = 1'b1; wait_n(3); strb_a = 1'b0; wait_n(2); strb_b = 1'b1;
        end
        cs_n = 1'b1; ad_i = 8'hEE; wait_n(2);
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [7:0] e, input string tag, input logic sel);
        logic seen;
        @(negedge clk);
        cs_n = ~sel;
        addr_phase(a);
        ad_i = 8'h5A;
        if (sel) sb_q.push_back('{val: e, tag: tag});
        seen = 1'b0;
        if (!bus_mode) strb_a = 1'b0;
        else begin strb_b = 1'b1; strb_a = 1'b1; end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (ad_oe) seen = 1'b1;
        end
        if (!sel) check(!seen, {tag, " deselected drive"}, {7'd0, seen}, 8'h00);
        if (!bus_mode) strb_a = 1'b1;
        else strb_a = 1'b0;
        wait_n(2);
        check(!ad_oe, {tag, " release"}, {7'd0, ad_oe}, 8'h00);
        cs_n = 1'b1; wait_n(2);
    endtask

    task automatic do_reset(input logic m);
        rst = 1'b1; bus_mode = m; cs_n = 1'b1; set_idle();
        wait_n(3); rst = 1'b0; wait_n(2);
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual 00 expected 01");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [7:0] MAP [9] = '{8'h15, 8'h1A, 8'h2B, 8'h2C, 8'h35, 8'h36, 8'h4D, 8'h4E, 8'h4F};

    initial begin
        do_reset(1'b0);
        // R1 reset state
        check(!ad_oe, "R1 oe after reset", {7'd0, ad_oe}, 8'h00);
        for (int i = 0; i < 9; i++) bus_read(MAP[i], 8'h00, "R1 reset value", 1'b1);

        // R2 R3 R4 R9: latch/read/write mode, distinct pattern per register
        for (int i = 0; i < 9; i++) bus_write(MAP[i], 8'hA0 + 8'(i * 7), 1'b1);
        for (int i = 0; i < 9; i++) bus_read(MAP[i], 8'hA0 + 8'(i * 7), "R3 R9 latch-mode readback", 1'b1);
        bus_write(8'h4E, 8'h3C, 1'b1);
        bus_read(8'h4E, 8'h3C, "R2 R4 address captured on strobe fall", 1'b1);
        bus_read(8'h4D, 8'hA0 + 8'd42, "R2 neighbour unaffected", 1'b1);

        // R7 deselected write and read
        bus_write(8'h4E, 8'h99, 1'b0);
        bus_read(8'h4E, 8'h00, "R7", 1'b0);
        bus_read(8'h4E, 8'h3C, "R7 register unchanged", 1'b1);

        // R8 unmapped address
        bus_write(8'h16, 8'h77, 1'b1);
        bus_read(8'h16, 8'h00, "R8 unmapped read", 1'b1);
        bus_read(8'h15, 8'hA0, "R8 neighbour unchanged", 1'b1);

        // Strobe/data/direction mode
        do_reset(1'b1);
        bus_read(8'h2B, 8'h00, "R1 reset value mode 1", 1'b1);
        bus_write(8'h2B, 8'h81, 1'b1);
        bus_write(8'h36, 8'h5E, 1'b1);
        bus_write(8'h4F, 8'hFF, 1'b1);
        bus_read(8'h2B, 8'h81, "R5 R6 strobe-mode readback", 1'b1);
        bus_read(8'h36, 8'h5E, "R5 R6 strobe-mode readback", 1'b1);
        bus_read(8'h4F, 8'hFF, "R2 R6 strobe-mode readback", 1'b1);
        bus_write(8'h36, 8'h11, 1'b0);
        bus_read(8'h36, 8'h5E, "R7 mode 1 deselected write", 1'b1);
        bus_write(8'hC0, 8'h22, 1'b1);
        bus_read(8'hC0, 8'h00, "R8 mode 1 unmapped", 1'b1);

        wait_n(4);
        check(sb_q.size() == 0, "R4 R6 missing drive phase", 8'(sb_q.size()), 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule